// File: doc/BRIEF.md
# Floating-Point Error Relay Bridge

This block connects a processor's legacy floating-point error pins to a packet-based host link. When the processor pulls its active-low error request low, the floating-point unit has stopped on an error. The bridge turns that falling edge into one broadcast error message for all downstream devices. The message waits on a valid/ready port until the link side takes it.

The bridge also watches a simple I/O write bus. The software error handler clears the error by writing zero to port F0h. The bridge recognises that write and forms an internal resume message. This message drives the active-low ignore-error output back to the processor, so the frozen unit starts again. The port write does not touch the processor directly: only the ignore-error pin does.

A mode input mirrors the processor's numeric-error control bit. While that input is 1, the bridge takes no part in error handling.

Top module: `fpu_err_bridge`

## Requirements
- R1: During and after reset, `ign_fpu_n` is 1 and `msg_valid` is 0. The synchronised error request starts inactive (high), so a request already held low through reset gives exactly one message after reset is released.
- R2: Each falling edge of `fpu_err_n` gives exactly one message with `msg_code` equal to `ERR_CODE` (default 8'hE1). `msg_valid` rises on the third rising clock edge after the input falls.
- R3: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and `msg_code` stays unchanged.
- R4: A falling edge that arrives while a message is still waiting merges into that message. Only one message is delivered.
- R5: An I/O write with address `CLEAR_PORT` (default 16'h00F0) and data `CLEAR_DATA` (default 8'h00), sampled on clock edge W, drives `ign_fpu_n` low after edge W+1.
- R6: An I/O write with any other address, or with the clear address and non-zero data, leaves `ign_fpu_n` high.
- R7: A clear write made while `fpu_err_n` is high holds `ign_fpu_n` low for exactly `MIN_PULSE` (default 4) clocks.
- R8: While the synchronised error request is low, `ign_fpu_n` stays low. It goes high on the third rising edge after `fpu_err_n` rises, provided the minimum pulse has elapsed.
- R9: While `numeric_err_en` is 1, error edges and clear writes are ignored: no message is raised and `ign_fpu_n` does not assert.
- R10: After `fpu_err_n` returns high, the edge detector re-arms, and a later falling edge gives a new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| numeric_err_en | input | 1 | 1 disables compatibility error relaying |
| fpu_err_n | input | 1 | Asynchronous active-low error request from the processor |
| io_wr_valid | input | 1 | I/O write strobe, one cycle per write |
| io_wr_addr | input | ADDR_W | I/O write port address |
| io_wr_data | input | DATA_W | I/O write data |
| msg_valid | output | 1 | Broadcast error message waiting |
| msg_ready | input | 1 | Link side accepts the message |
| msg_code | output | MSG_W | Message type code |
| ign_fpu_n | output | 1 | Active-low ignore-error output to the processor |

## Verification
The bench holds the error request low through reset. A design that reset its synchroniser to the active level would never see the edge and would lose that message. It stalls the link ready while the request toggles twice, and it then expects exactly one message: a bridge that queued or replayed edges would deliver two. It sends clear writes with a neighbouring address and with non-zero data, expecting no resume. It also measures the resume pulse both with no error pending and with the error held, so a wrong counter limit or a release that ignores the error level shows up as a miscounted low time.

// File: rtl/fpu_err_pkg.sv
package fpu_err_pkg;

   // State of the ignore-error pin driver
   typedef enum logic {
      IGN_IDLE = 1'b0,
      IGN_HOLD = 1'b1
   } ign_state_t;

   // Internal resume message passed from the I/O decoder to the pin driver
   typedef struct packed {
      logic hit;
   } resume_msg_t;

endpackage

// File: rtl/fpu_err_sync.sv
module fpu_err_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fpu_err_msg_gen.sv
module fpu_err_msg_gen #(
   parameter int             MSG_W    = 8,
   parameter logic [MSG_W-1:0] ERR_CODE = 8'hE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             err_sync_n,
   output logic             msg_valid,
   input  logic             msg_ready,
   output logic [MSG_W-1:0] msg_code
);

   logic prev_n;
   logic fall;
   logic valid_d;

   // Falling edge of the synchronised request; prev resets inactive
   assign fall    = prev_n & ~err_sync_n;
   // Pending flag: held until accepted, a new edge while pending merges
   assign valid_d = (msg_valid & ~msg_ready) | (fall & enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n    <= 1'b1;
         msg_valid <= 1'b0;
         msg_code  <= '0;
      end else begin
         prev_n    <= err_sync_n;
         msg_valid <= valid_d;
         msg_code  <= valid_d ? ERR_CODE : '0;
      end
   end

endmodule

// File: rtl/fpu_err_io_decode.sv
module fpu_err_io_decode
   import fpu_err_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] CLEAR_PORT = 16'h00F0,
   parameter logic [DATA_W-1:0] CLEAR_DATA = 8'h00,
   parameter bit                CHECK_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output resume_msg_t       resume
);

   logic port_match;
   logic data_match;

   assign port_match = (wr_addr == CLEAR_PORT);

   generate
      if (CHECK_DATA) begin : g_data_chk
         assign data_match = (wr_data == CLEAR_DATA);
      end else begin : g_data_any
         assign data_match = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resume.hit <= 1'b0;
      else        resume.hit <= enable & wr_valid & port_match & data_match;
   end

endmodule

// File: rtl/fpu_err_ignore_drv.sv
module fpu_err_ignore_drv
   import fpu_err_pkg::*;
#(
   parameter int MIN_PULSE = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  resume_msg_t resume,
   input  logic        err_sync_n,
   output logic        ign_n
);

   localparam int CNT_W = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULSE - 1);

   ign_state_t       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= IGN_IDLE;
         cnt   <= '0;
      end else if (resume.hit && enable) begin
         state <= IGN_HOLD;
         cnt   <= '0;
      end else if (state == IGN_HOLD) begin
         if (cnt != LAST)  cnt   <= cnt + 1'b1;
         else if (err_sync_n) state <= IGN_IDLE;
      end
   end

   assign ign_n = (state != IGN_HOLD);

endmodule

// File: rtl/fpu_err_bridge.sv
module fpu_err_bridge
   import fpu_err_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                MSG_W       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter int                MIN_PULSE   = 4,
   parameter bit                CHECK_DATA  = 1'b1,
   parameter logic [ADDR_W-1:0] CLEAR_PORT  = 16'h00F0,
   parameter logic [DATA_W-1:0] CLEAR_DATA  = 8'h00,
   parameter logic [MSG_W-1:0]  ERR_CODE    = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              numeric_err_en,
   input  logic              fpu_err_n,
   input  logic              io_wr_valid,
   input  logic [ADDR_W-1:0] io_wr_addr,
   input  logic [DATA_W-1:0] io_wr_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [MSG_W-1:0]  msg_code,
   output logic              ign_fpu_n
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_PULSE < 2) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 2");
      end
      if (ADDR_W < 8 || DATA_W < 8 || MSG_W < 1) begin : g_bad_width
         $error("bus widths out of range");
      end
   endgenerate

   logic        relay_on;
   logic        err_sync_n;
   resume_msg_t resume;

   assign relay_on = ~numeric_err_en;

   fpu_err_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fpu_err_n),
      .q     (err_sync_n)
   );

   fpu_err_msg_gen #(
      .MSG_W    (MSG_W),
      .ERR_CODE (ERR_CODE)
   ) u_msg (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (relay_on),
      .err_sync_n (err_sync_n),
      .msg_valid  (msg_valid),
      .msg_ready  (msg_ready),
      .msg_code   (msg_code)
   );

   fpu_err_io_decode #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CLEAR_PORT (CLEAR_PORT),
      .CLEAR_DATA (CLEAR_DATA),
      .CHECK_DATA (CHECK_DATA)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (relay_on),
      .wr_valid (io_wr_valid),
      .wr_addr  (io_wr_addr),
      .wr_data  (io_wr_data),
      .resume   (resume)
   );

   fpu_err_ignore_drv #(
      .MIN_PULSE (MIN_PULSE)
   ) u_ign (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (relay_on),
      .resume     (resume),
      .err_sync_n (err_sync_n),
      .ign_n      (ign_fpu_n)
   );

endmodule

// File: rtl/fpu_err_bridge_chk.sv
module fpu_err_bridge_chk #(
   parameter int MSG_W     = 8,
   parameter int MIN_PULSE = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             numeric_err_en,
   input logic             err_sync_n,
   input logic             clr_hit,
   input logic             msg_valid,
   input logic             msg_ready,
   input logic [MSG_W-1:0] msg_code,
   input logic             ign_fpu_n
);

   logic [7:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= '0;
      else if (ign_fpu_n)  low_cnt <= '0;
      else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
   end

   assert_msg_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> ($past(err_sync_n) == 1'b0));

   assert_msg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_code)));

   assert_ign_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ign_fpu_n) |-> $past(clr_hit));

   assert_ign_min_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ign_fpu_n) |-> (low_cnt >= 8'(MIN_PULSE)));

   assert_ign_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ign_fpu_n && !err_sync_n) |=> !ign_fpu_n);

   assert_off_no_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (numeric_err_en && !msg_valid) |=> !msg_valid);

   assert_off_no_ign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (numeric_err_en && ign_fpu_n) |=> ign_fpu_n);

endmodule

bind fpu_err_bridge fpu_err_bridge_chk #(
   .MSG_W     (MSG_W),
   .MIN_PULSE (MIN_PULSE)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .numeric_err_en (numeric_err_en),
   .err_sync_n     (err_sync_n),
   .clr_hit        (resume.hit),
   .msg_valid      (msg_valid),
   .msg_ready      (msg_ready),
   .msg_code       (msg_code),
   .ign_fpu_n      (ign_fpu_n)
);

// File: tb/test_fpu_err_bridge.sv
module test_fpu_err_bridge;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] ERR_CODE = 8'hE1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        numeric_err_en = 1'b0;
   logic        fpu_err_n = 1'b0;
   logic        io_wr_valid = 1'b0;
   logic [15:0] io_wr_addr = '0;
   logic [7:0]  io_wr_data = '0;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [7:0]  msg_code;
   logic        ign_fpu_n;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_err_bridge i_fpu_err_bridge (
      .clk            (clk),
      .rst_n          (rst_n),
      .numeric_err_en (numeric_err_en),
      .fpu_err_n      (fpu_err_n),
      .io_wr_valid    (io_wr_valid),
      .io_wr_addr     (io_wr_addr),
      .io_wr_data     (io_wr_data),
      .msg_valid      (msg_valid),
      .msg_ready      (msg_ready),
      .msg_code       (msg_code),
      .ign_fpu_n      (ign_fpu_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver side of the scoreboard: one expected message per requested edge
   task automatic expect_msg();
      exp_q.push_back(ERR_CODE);
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      io_wr_valid = 1'b1;
      io_wr_addr  = a;
      io_wr_data  = d;
      @(negedge clk);
      io_wr_valid = 1'b0;
   endtask

   task automatic count_low(input int n, output int lows);
      lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!ign_fpu_n) lows++;
      end
   endtask

   // monitor side: pop and compare on each handshake
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         vectors++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2/R4/R9: actual unexpected message %0h expected none", msg_code);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (msg_code !== e) begin
               fails++;
               $display("FAIL R2: actual code %0h expected %0h", msg_code, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int lows;
      // R1: reset state with error request held low through reset
      cycles(3);
      check("R1 ign", ign_fpu_n, 1);
      check("R1 valid", msg_valid, 0);
      expect_msg();
      rst_n = 1'b1;
      cycles(12);
      check("R1 queue drained", exp_q.size(), 0);

      // R10: re-arm after the request returns high
      fpu_err_n = 1'b1;
      cycles(5);
      fpu_err_n = 1'b0;
      expect_msg();
      // R2: valid rises on the third edge after the fall
      msg_ready = 1'b0;
      cycles(2);
      check("R2 not yet", msg_valid, 0);
      cycles(1);
      check("R2 valid", msg_valid, 1);
      // R3: held while ready is low
      for (int i = 0; i < 5; i++) begin
         cycles(1);
         check("R3 held valid", msg_valid, 1);
         check("R3 held code", msg_code, ERR_CODE);
      end
      msg_ready = 1'b1;
      cycles(3);
      check("R10 queue drained", exp_q.size(), 0);

      // R4: second edge while pending merges
      fpu_err_n = 1'b1;
      cycles(5);
      msg_ready = 1'b0;
      fpu_err_n = 1'b0;
      expect_msg();
      cycles(5);
      fpu_err_n = 1'b1;
      cycles(4);
      fpu_err_n = 1'b0;
      cycles(5);
      check("R4 still pending", msg_valid, 1);
      msg_ready = 1'b1;
      cycles(10);
      check("R4 single delivery", exp_q.size(), 0);

      // R5/R7: clear write with no error pending
      fpu_err_n = 1'b1;
      cycles(6);
      io_write(16'h00F0, 8'h00);
      check("R5 not yet", ign_fpu_n, 1);
      cycles(1);
      check("R5 asserted", ign_fpu_n, 0);
      count_low(10, lows);
      check("R7 pulse length", lows + 1, 4);

      // R6: neighbouring port and non-zero data
      io_write(16'h00F1, 8'h00);
      count_low(6, lows);
      check("R6 wrong port", lows, 0);
      io_write(16'h00F0, 8'h01);
      count_low(6, lows);
      check("R6 wrong data", lows, 0);

      // R8: hold while error low, release on third edge after rise
      fpu_err_n = 1'b0;
      expect_msg();
      cycles(8);
      io_write(16'h00F0, 8'h00);
      count_low(12, lows);
      check("R8 held low", lows, 12);
      fpu_err_n = 1'b1;
      cycles(2);
      check("R8 still low", ign_fpu_n, 0);
      cycles(1);
      check("R8 released", ign_fpu_n, 1);
      check("R8 queue drained", exp_q.size(), 0);

      // R9: disabled mode ignores edges and writes
      cycles(4);
      numeric_err_en = 1'b1;
      cycles(1);
      fpu_err_n = 1'b0;
      cycles(6);
      io_write(16'h00F0, 8'h00);
      count_low(8, lows);
      check("R9 no ignore", lows, 0);
      check("R9 no message", msg_valid, 0);
      fpu_err_n = 1'b1;
      cycles(5);
      numeric_err_en = 1'b0;
      cycles(5);
      check("R9 no late message", msg_valid, 0);
      check("R9 queue empty", exp_q.size(), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule